// File: doc/BRIEF.md
# Byte-Bus Converter Interface Core

This block is the digital front of a 12-bit converter whose control input and data output share one byte-wide bus. A host selects the block with an active-low chip select, writes a control byte with an active-low write strobe, and later reads the 12-bit result as two bytes. An active-low read strobe gates the read, and a high-byte select picks which byte. The bus is three-state: it is modelled as an input byte, an output byte and a drive enable.

The control byte picks the conversion clock source, the output polarity and the power state. Any write that asks for normal power starts a conversion. With the internal clock, a cycle counter stands in for the 3.6 µs conversion time. With the external clock, twelve rising edges of a separate conversion clock complete the conversion. When the conversion ends, the raw code on the `adc_code` port is formatted and stored. A write that asks for power-down keeps the previously chosen clock mode.

The engine is a three-state machine. IDLE goes to CONV_INT or CONV_EXT on an accepted start. CONV_INT goes back to IDLE when its cycle count runs out. CONV_EXT goes back to IDLE on its twelfth counted conversion-clock step. In both cases the return to IDLE is the cycle in which the result register is loaded.

Top module: `pbus_adc_core`

## Requirements
- R1: After reset, `clk_ext` is 1 (external clock mode), `busy` is 0, `bus_oe` is 0 and the stored result is zero, so both bytes read back as 0x00.
- R2: A control byte is taken from `bus_in` in the first clock cycle where `cs_n` and `wr_n` are both low. Its fields are: [7:6] clock select, [2] polarity (1 = bipolar), [1:0] power (2'b00 = run and start a conversion, any other value = power-down request). Bits [5:3] are reserved.
- R3: With power 2'b00, clock select 2'b10 sets internal mode (`clk_ext` = 0) and 2'b11 sets external mode (`clk_ext` = 1). Select values 2'b0x keep the current mode.
- R4: A write whose power field is not 2'b00 starts no conversion and leaves `clk_ext` unchanged, whatever its clock select bits are.
- R5: While `cs_n` is high, `bus_oe` is 0, writes are not taken, and conversion-clock edges are not counted.
- R6: `bus_oe` is 1 only while `cs_n` and `rd_n` are both low.
- R7: With `hbe` = 0, a read places result bits [7:0] on `bus_out`.
- R8: With `hbe` = 1, a read places result bits [11:8] on `bus_out[3:0]`. `bus_out[7:4]` is 0 in unipolar mode and copies result bit 11 in bipolar mode.
- R9: The stored result equals `adc_code` in unipolar mode. In bipolar mode it is `adc_code` with bit 11 inverted, which is the two's complement of the offset-binary input.
- R10: In internal mode, `busy` stays high for exactly INT_CYCLES clock cycles after the accepting edge. INT_CYCLES = 180 at the default 50 MHz.
- R11: In external mode, the conversion completes after the twelfth rising `conv_clk` edge that is counted while `cs_n` is low.
- R12: `busy` rises only on an accepted start. While `busy` is high, writes are ignored and reads return the previous result. A read held across the completing edge shows the old value before that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| hbe | input | 1 | High-byte select for reads |
| conv_clk | input | 1 | External conversion clock, asynchronous |
| bus_in | input | 8 | Bus value seen by the block |
| bus_out | output | 8 | Bus value driven by the block |
| bus_oe | output | 1 | Three-state drive enable for `bus_out` |
| adc_code | input | 12 | Raw conversion code from the converter |
| busy | output | 1 | High from conversion start until the result is stored |
| clk_ext | output | 1 | Current clock mode, 1 = external |

## Verification
Two functions can fall in the same cycle here: a host read of the result, and the completion edge that overwrites that result. The bench provokes this by holding a low-byte read active through an internal conversion. It samples the bus at the falling edge just before the final count and again one cycle later, and expects the old byte first and then the newly formatted byte. A second overlap is a power-down write issued while a conversion is running. The bench judges this at the ports: `clk_ext` must keep its value, and the running conversion must still finish on its normal step count.

// File: rtl/pbus_adc_pkg.sv
package pbus_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CONV_INT = 2'd1,
        ST_CONV_EXT = 2'd2
    } conv_state_t;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [2:0] rsvd;
        logic       bipolar;
        logic [1:0] pwr;
    } ctrl_byte_t;

    localparam logic [1:0] PWR_RUN = 2'b00;

endpackage

// File: rtl/pbus_ctrl_capture.sv
module pbus_ctrl_capture
    import pbus_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wr_n,
    input  logic       busy,
    input  logic [7:0] bus_in,
    output logic       clk_ext,
    output logic       bipolar,
    output logic       start,
    output logic       start_ext
);

    ctrl_byte_t ctrl;
    logic       wr_act;
    logic       wr_act_q;
    logic       accept;
    logic       run_req;
    logic       unused_rsvd;

    assign ctrl        = ctrl_byte_t'(bus_in);
    assign unused_rsvd = ^ctrl.rsvd;
    assign wr_act      = !cs_n && !wr_n;
    assign accept      = wr_act && !wr_act_q && !busy;
    assign run_req     = (ctrl.pwr == PWR_RUN);

    // mode for a conversion that starts on this edge
    assign start_ext = (run_req && ctrl.clk_sel[1]) ? ctrl.clk_sel[0] : clk_ext;
    assign start     = accept && run_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            clk_ext  <= 1'b1;
            bipolar  <= 1'b0;
        end else begin
            wr_act_q <= wr_act;
            if (accept) begin
                bipolar <= ctrl.bipolar;
                clk_ext <= start_ext;
            end
        end
    end

endmodule

// File: rtl/pbus_conv_engine.sv
module pbus_conv_engine
    import pbus_adc_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int INT_CYCLES = 180,
    parameter int EXT_STEPS  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             conv_clk,
    input  logic             start,
    input  logic             start_ext,
    input  logic             bipolar,
    input  logic [RES_W-1:0] adc_code,
    output logic             busy,
    output logic [RES_W-1:0] result
);

    localparam int MAX_CNT = (INT_CYCLES > EXT_STEPS) ? INT_CYCLES : EXT_STEPS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXT_STEPS - 1);

    conv_state_t      state;
    conv_state_t      state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             cc_s1;
    logic             cc_s2;
    logic             cc_q;
    logic             step;
    logic             finish;

    // two-flop synchroniser and rising-edge detect for the conversion clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_s1 <= 1'b0;
            cc_s2 <= 1'b0;
            cc_q  <= 1'b0;
        end else begin
            cc_s1 <= conv_clk;
            cc_s2 <= cc_s1;
            cc_q  <= cc_s2;
        end
    end

    assign step = cc_s2 && !cc_q && !cs_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nxt = start_ext ? ST_CONV_EXT : ST_CONV_INT;
            end
            ST_CONV_INT: begin
                if (cnt == INT_LAST) state_nxt = ST_IDLE;
            end
            ST_CONV_EXT: begin
                if (step && cnt == EXT_LAST) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        finish = busy && (state_nxt == ST_IDLE);
    end

    // step counter and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            result <= '0;
        end else begin
            if (start && !busy)                     cnt <= '0;
            else if (state == ST_CONV_INT)          cnt <= cnt + 1'b1;
            else if (state == ST_CONV_EXT && step)  cnt <= cnt + 1'b1;
            if (finish) begin
                result <= bipolar ? {~adc_code[RES_W-1], adc_code[RES_W-2:0]} : adc_code;
            end
        end
    end

endmodule

// File: rtl/pbus_read_mux.sv
module pbus_read_mux #(
    parameter int DATA_W = 8,
    parameter int RES_W  = 12
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              hbe,
    input  logic              bipolar,
    input  logic [RES_W-1:0]  result,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    localparam int HI_W   = RES_W - DATA_W;
    localparam int FILL_W = DATA_W - HI_W;

    logic [FILL_W-1:0] fill;

    assign fill    = bipolar ? {FILL_W{result[RES_W-1]}} : '0;
    assign bus_oe  = !cs_n && !rd_n;
    assign bus_out = hbe ? {fill, result[RES_W-1:DATA_W]} : result[DATA_W-1:0];

endmodule

// File: rtl/pbus_adc_core.sv
module pbus_adc_core #(
    parameter int DATA_W    = 8,
    parameter int RES_W     = 12,
    parameter int CLK_KHZ   = 50000,
    parameter int CONV_NS   = 3600,
    parameter int EXT_STEPS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              hbe,
    input  logic              conv_clk,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [RES_W-1:0]  adc_code,
    output logic              busy,
    output logic              clk_ext
);

    localparam int INT_CYCLES = (CLK_KHZ * CONV_NS) / 1000000;

    logic             bipolar;
    logic             start;
    logic             start_ext;
    logic [RES_W-1:0] result;

    pbus_ctrl_capture u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .busy      (busy),
        .bus_in    (bus_in),
        .clk_ext   (clk_ext),
        .bipolar   (bipolar),
        .start     (start),
        .start_ext (start_ext)
    );

    pbus_conv_engine #(
        .RES_W      (RES_W),
        .INT_CYCLES (INT_CYCLES),
        .EXT_STEPS  (EXT_STEPS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .conv_clk  (conv_clk),
        .start     (start),
        .start_ext (start_ext),
        .bipolar   (bipolar),
        .adc_code  (adc_code),
        .busy      (busy),
        .result    (result)
    );

    pbus_read_mux #(
        .DATA_W (DATA_W),
        .RES_W  (RES_W)
    ) u_rd (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .hbe     (hbe),
        .bipolar (bipolar),
        .result  (result),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

endmodule

// File: rtl/pbus_adc_core_chk.sv
module pbus_adc_core_chk #(
    parameter int DATA_W = 8,
    parameter int RES_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              rd_n,
    input logic              hbe,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic              busy,
    input logic              clk_ext
);

    localparam int HI_W = RES_W - DATA_W;

    assert_hiz_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

    assert_no_drive_without_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !bus_oe);

    assert_pd_keeps_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && !wr_n && bus_in[1:0] != 2'b00 && $past(cs_n || wr_n))
        |=> ($stable(clk_ext) && !busy));

    assert_high_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && hbe && bus_out[DATA_W-1:HI_W] != '0)
        |-> (bus_out[DATA_W-1:HI_W] == {(DATA_W-HI_W){bus_out[HI_W-1]}}));

    assert_busy_needs_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs_n && !wr_n));

    assert_mode_frozen_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(clk_ext));

endmodule

bind pbus_adc_core pbus_adc_core_chk #(.DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .hbe     (hbe),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .busy    (busy),
    .clk_ext (clk_ext)
);

// File: tb/pbus_adc_core_tb.sv
module pbus_adc_core_tb;

    localparam int N_INT = 180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hbe = 1'b0;
    logic        conv_clk = 1'b0;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [11:0] adc_code = 12'h000;
    logic        busy;
    logic        clk_ext;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] prev_res;

    always #10 clk = ~clk;

    pbus_adc_core u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hbe(hbe), .conv_clk(conv_clk), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .adc_code(adc_code), .busy(busy), .clk_ext(clk_ext)
    );

    function automatic logic [11:0] fmt(input logic [11:0] c, input logic bip);
        return bip ? (c ^ 12'h800) : c;
    endfunction

    function automatic logic [7:0] hi_of(input logic [11:0] r, input logic bip);
        return {(bip ? {4{r[11]}} : 4'h0), r[11:8]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        bus_in = b; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic rd_byte(input logic h, output logic [7:0] d, output logic oe);
        cs_n = 1'b0; rd_n = 1'b0; hbe = h;
        #2;
        d = bus_out; oe = bus_oe;
        #1;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic ext_pulse(input logic sel_low);
        cs_n = !sel_low;
        conv_clk = 1'b1;
        repeat (3) @(negedge clk);
        conv_clk = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    endtask

    task automatic check_result(input string req, input logic [11:0] r, input logic bip);
        logic [7:0] d;
        logic oe;
        rd_byte(1'b0, d, oe);
        check(req, {8'h0, d}, {8'h0, r[7:0]});
        rd_byte(1'b1, d, oe);
        check(req, {8'h0, d}, {8'h0, hi_of(r, bip)});
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        int n;
        logic [11:0] code;
        logic bip;
        logic ext;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 clk_ext", {15'h0, clk_ext}, 16'h1);
        check("R1 busy", {15'h0, busy}, 16'h0);
        check("R1 bus_oe", {15'h0, bus_oe}, 16'h0);
        check_result("R1 result", 12'h000, 1'b0);

        // R5 / R6 drive rules
        rd_n = 1'b0; #2;
        check("R5 deselected no drive", {15'h0, bus_oe}, 16'h0);
        rd_n = 1'b1; cs_n = 1'b0; #2;
        check("R6 no read no drive", {15'h0, bus_oe}, 16'h0);
        cs_n = 1'b1;
        @(negedge clk);

        // R5 write ignored while deselected
        bus_in = 8'h80; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        check("R5 write ignored busy", {15'h0, busy}, 16'h0);
        check("R5 write ignored mode", {15'h0, clk_ext}, 16'h1);

        // R2 R3 R10 internal unipolar conversion
        adc_code = 12'hA5C;
        wr_byte(8'h80);
        check("R3 internal mode", {15'h0, clk_ext}, 16'h0);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R10 busy length", n[15:0], 16'(N_INT));
        check_result("R7 R8 R9 unipolar", 12'hA5C, 1'b0);

        // R9 R8 bipolar conversion
        adc_code = 12'h3F1;
        wr_byte(8'h84);
        wait_idle();
        check_result("R9 bipolar", 12'hBF1, 1'b1);
        prev_res = 12'hBF1;

        // R4 power-down keeps mode
        wr_byte(8'hC1);
        @(negedge clk);
        check("R4 mode kept", {15'h0, clk_ext}, 16'h0);
        check("R4 no conversion", {15'h0, busy}, 16'h0);

        // R11 external conversion
        adc_code = 12'h123;
        wr_byte(8'hC0);
        check("R3 external mode", {15'h0, clk_ext}, 16'h1);
        check("R12 busy at start", {15'h0, busy}, 16'h1);
        rd_byte(1'b0, d, oe);
        check("R12 read during busy", {8'h0, d}, {8'h0, prev_res[7:0]});
        wr_byte(8'h81);
        check("R12 write during busy ignored", {15'h0, clk_ext}, 16'h1);
        for (int i = 0; i < 12; i++) ext_pulse(1'b0 == 1'b1);
        check("R5 edges ignored deselected", {15'h0, busy}, 16'h1);
        for (int i = 0; i < 11; i++) ext_pulse(1'b1);
        check("R11 still busy after 11", {15'h0, busy}, 16'h1);
        ext_pulse(1'b1);
        check("R11 done after 12", {15'h0, busy}, 16'h0);
        check_result("R11 ext result", 12'h123, 1'b0);
        check("R12 mode after ignored write", {15'h0, clk_ext}, 16'h1);

        // R12 read across completion edge
        adc_code = 12'h0E7;
        wr_byte(8'h80);
        cs_n = 1'b0; rd_n = 1'b0; hbe = 1'b0;
        repeat (N_INT - 1) @(negedge clk);
        check("R12 old before edge", {8'h0, bus_out}, 16'h0023);
        check("R12 busy before edge", {15'h0, busy}, 16'h1);
        @(negedge clk);
        check("R12 new after edge", {8'h0, bus_out}, 16'h00E7);
        check("R12 idle after edge", {15'h0, busy}, 16'h0);
        cs_n = 1'b1; rd_n = 1'b1;

        // random conversions
        for (int it = 0; it < 16; it++) begin
            code = 12'($urandom);
            bip  = 1'($urandom);
            ext  = 1'($urandom);
            adc_code = code;
            wr_byte({1'b1, ext, 3'b000, bip, 2'b00});
            check("R3 random mode", {15'h0, clk_ext}, {15'h0, ext});
            if (ext) begin
                for (int i = 0; i < 12; i++) ext_pulse(1'b1);
            end
            wait_idle();
            check("R10 R11 random done", {15'h0, busy}, 16'h0);
            check_result("R9 random result", fmt(code, bip), bip);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule